// File: doc/BRIEF.md
# Dual-Port Lookup-Table RAM

This block is a tiny random-access memory with two read ports. It holds 16 words by default, and each word is one bit wide. The first port reads and writes through its own address. The second port only reads, and it has an address of its own that is fully independent of the first. Writes happen on one edge of the write clock, and only when the write enable is active. Both reads are combinational, so a read needs neither a clock nor an enable.

Parameters shape the block at elaboration time:

- The power-up contents of the memory.
- The word width and the address width.
- Whether the write clock is active on its rising or its falling edge.
- Whether the write enable is active high or active low.
- For each read port separately, whether it drives its output straight from the array or through an output register.

An output register is clocked on the same active write edge as the array. It is cleared by an asynchronous active-low reset, and that reset is released in step with the write clock. The memory array itself is never reset.

Top module: `lutram_dp`

## Requirements
- R1: After power-up, word i of the array holds bits `[i*DATA_W +: DATA_W]` of the `INIT` parameter, for every address i from 0 to 15 at the default width.
- R2: If `wr_en` is active on an active clock edge, `wr_data` is stored at the location selected by `rw_addr`.
- R3: If `wr_en` is inactive on an active clock edge, no word of the array changes.
- R4: In combinational mode, `rw_q` shows the word at `rw_addr` and `ro_q` shows the word at `ro_addr`. Each follows its own address, and the two addresses are independent. Both ports may read the same address at the same time.
- R5: Once an active write edge has passed, a combinational `rw_q` shows the newly written value. A combinational `ro_q` shows it as well when `ro_addr` equals the write address.
- R6: With `CLK_INV` = 1 the active edge is the falling edge of `wr_clk`. With `CLK_INV` = 0 it is the rising edge.
- R7: With `WE_INV` = 1 the write enable is active when `wr_en` = 0. With `WE_INV` = 0 it is active when `wr_en` = 1.
- R8: A read port set to registered mode (`RD_REG`) captures its combinational read value on every active edge once reset has been released. The value captured is the one present before that edge's write. The output then shows the captured value until the next active edge.
- R9: A registered output reads 0 while `rst_n` is low. It keeps reading 0 until the second active edge after `rst_n` rises, and it captures read data from the third such edge onward. Reset never alters the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; its active edge is chosen by `CLK_INV` |
| rst_n | input | 1 | Asynchronous active-low reset for the output registers |
| wr_en | input | 1 | Write enable; its polarity is chosen by `WE_INV` |
| wr_data | input | DATA_W | Word to be written |
| rw_addr | input | ADDR_W | Address for the read/write port |
| ro_addr | input | ADDR_W | Address for the read-only port |
| rw_q | output | DATA_W | Read data from the read/write port |
| ro_q | output | DATA_W | Read data from the read-only port |

## Verification
The bench builds four copies of the block, all with a 1-bit word and a non-zero `INIT` pattern. Together the copies cover all four combinations of clock polarity and enable polarity. Each copy puts a different pair of read ports in registered mode, so every output mode appears next to every polarity. The copies share one stimulus: the inverted-clock copies get the complement of the bench clock, and the active-low copies get the complement of the enable. As a result, all four copies must agree with one reference array on every cycle. This brings several things within reach at once: the registered read latency, reset release, and same-address reads across both edge choices.

// File: rtl/lutram_pkg.sv
package lutram_pkg;

  // How a read port presents its data.
  typedef enum logic {
    RD_COMB = 1'b0,
    RD_REG  = 1'b1
  } rd_mode_e;

  // Depth of the reset release chain, in active clock edges.
  localparam int unsigned RST_SYNC_STAGES = 2;

endpackage

// File: rtl/lutram_rst_sync.sv
module lutram_rst_sync
  import lutram_pkg::*;
(
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_sync_no
);

  logic [RST_SYNC_STAGES-1:0] chain_q;
  logic [RST_SYNC_STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[RST_SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_no = chain_q[RST_SYNC_STAGES-1];

endmodule

// File: rtl/lutram_store.sv
module lutram_store #(
  parameter int unsigned DATA_W = 1,
  parameter int unsigned ADDR_W = 4,
  parameter logic [(2**ADDR_W)*DATA_W-1:0] INIT = '0
) (
  input  logic              clk_i,
  input  logic              wr_act_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd0_addr_i,
  input  logic [ADDR_W-1:0] rd1_addr_i,
  output logic [DATA_W-1:0] rd0_data_o,
  output logic [DATA_W-1:0] rd1_data_o
);

  localparam int unsigned DEPTH = 2**ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] mem_d [DEPTH];

  // Power-up contents of the array; the array has no reset.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_q[i] = INIT[i*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
    end
    if (wr_act_i) begin
      mem_d[wr_addr_i] = wr_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_q[i] <= mem_d[i];
    end
  end

  assign rd0_data_o = mem_q[rd0_addr_i];
  assign rd1_data_o = mem_q[rd1_addr_i];

endmodule

// File: rtl/lutram_rd_stage.sv
module lutram_rd_stage
  import lutram_pkg::*;
#(
  parameter int unsigned DATA_W = 1,
  parameter rd_mode_e    MODE   = RD_COMB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] q_o
);

  generate
    if (MODE == RD_REG) begin : g_reg
      logic              ce;
      logic [DATA_W-1:0] q_d;
      logic [DATA_W-1:0] q_q;

      assign ce = 1'b1;

      always_comb begin
        q_d = q_q;
        if (ce) begin
          q_d = raw_i;
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q_q <= '0;
        end else begin
          q_q <= q_d;
        end
      end

      assign q_o = q_q;
    end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl = clk_i ^ rst_ni;
      assign q_o        = raw_i;
    end
  endgenerate

endmodule

// File: rtl/lutram_dp.sv
module lutram_dp
  import lutram_pkg::*;
#(
  parameter int unsigned DATA_W  = 1,
  parameter int unsigned ADDR_W  = 4,
  parameter logic [(2**ADDR_W)*DATA_W-1:0] INIT = '0,
  parameter bit          CLK_INV = 1'b0,
  parameter bit          WE_INV  = 1'b0,
  parameter rd_mode_e    RW_MODE = RD_COMB,
  parameter rd_mode_e    RO_MODE = RD_COMB
) (
  input  logic              wr_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rw_addr,
  input  logic [ADDR_W-1:0] ro_addr,
  output logic [DATA_W-1:0] rw_q,
  output logic [DATA_W-1:0] ro_q
);

  logic              clk_act;
  logic              wr_act;
  logic              rst_sync_n;
  logic [DATA_W-1:0] rw_raw;
  logic [DATA_W-1:0] ro_raw;

  // Polarity is resolved once, so everything below runs on rising edges
  // with an active-high enable.
  assign clk_act = wr_clk ^ CLK_INV;
  assign wr_act  = wr_en ^ WE_INV;

  lutram_rst_sync u_rst_sync (
    .clk_i       (clk_act),
    .arst_ni     (rst_n),
    .rst_sync_no (rst_sync_n)
  );

  lutram_store #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .INIT   (INIT)
  ) u_store (
    .clk_i      (clk_act),
    .wr_act_i   (wr_act),
    .wr_addr_i  (rw_addr),
    .wr_data_i  (wr_data),
    .rd0_addr_i (rw_addr),
    .rd1_addr_i (ro_addr),
    .rd0_data_o (rw_raw),
    .rd1_data_o (ro_raw)
  );

  lutram_rd_stage #(
    .DATA_W (DATA_W),
    .MODE   (RW_MODE)
  ) u_rw_stage (
    .clk_i  (clk_act),
    .rst_ni (rst_sync_n),
    .raw_i  (rw_raw),
    .q_o    (rw_q)
  );

  lutram_rd_stage #(
    .DATA_W (DATA_W),
    .MODE   (RO_MODE)
  ) u_ro_stage (
    .clk_i  (clk_act),
    .rst_ni (rst_sync_n),
    .raw_i  (ro_raw),
    .q_o    (ro_q)
  );

endmodule

// File: rtl/lutram_dp_chk.sv
module lutram_dp_chk
  import lutram_pkg::*;
#(
  parameter int unsigned DATA_W  = 1,
  parameter int unsigned ADDR_W  = 4,
  parameter bit          CLK_INV = 1'b0,
  parameter bit          WE_INV  = 1'b0,
  parameter rd_mode_e    RW_MODE = RD_COMB,
  parameter rd_mode_e    RO_MODE = RD_COMB
) (
  input logic              wr_clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rw_addr,
  input logic [ADDR_W-1:0] ro_addr,
  input logic [DATA_W-1:0] rw_q,
  input logic [DATA_W-1:0] ro_q,
  input logic [DATA_W-1:0] rw_raw,
  input logic [DATA_W-1:0] ro_raw,
  input logic              rst_sync_n
);

  logic ck;
  logic we_on;

  assign ck    = wr_clk ^ CLK_INV;
  assign we_on = wr_en ^ WE_INV;

  generate
    if (RW_MODE == RD_COMB) begin : g_rw_comb
      // R5: the word written last shows on the read/write port
      p_rw_new_data_r5: assert property (@(posedge ck) disable iff (!rst_n)
        we_on |=> (!$stable(rw_addr) || rw_q == $past(wr_data)));
      // R3: with no write, a steady address gives steady data
      p_rw_idle_hold_r3: assert property (@(posedge ck) disable iff (!rst_n)
        !we_on |=> (!$stable(rw_addr) || $stable(rw_q)));
    end else begin : g_rw_reg
      // R8: the registered port shows what the array gave one edge earlier
      p_rw_latency_r8: assert property (@(posedge ck) disable iff (!rst_sync_n)
        $past(rst_sync_n) |-> rw_q == $past(rw_raw));
    end

    if (RO_MODE == RD_COMB) begin : g_ro_comb
      // R5: a same-address read on the read-only port sees the write
      p_ro_same_addr_r5: assert property (@(posedge ck) disable iff (!rst_n)
        (we_on && ro_addr == rw_addr) |=>
          (!$stable(ro_addr) || ro_q == $past(wr_data)));
      // R3: with no write, the read-only port holds
      p_ro_idle_hold_r3: assert property (@(posedge ck) disable iff (!rst_n)
        !we_on |=> (!$stable(ro_addr) || $stable(ro_q)));
    end else begin : g_ro_reg
      // R8
      p_ro_latency_r8: assert property (@(posedge ck) disable iff (!rst_sync_n)
        $past(rst_sync_n) |-> ro_q == $past(ro_raw));
    end
  endgenerate

endmodule

bind lutram_dp lutram_dp_chk #(
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .CLK_INV (CLK_INV),
  .WE_INV  (WE_INV),
  .RW_MODE (RW_MODE),
  .RO_MODE (RO_MODE)
) u_chk (
  .wr_clk     (wr_clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rw_addr    (rw_addr),
  .ro_addr    (ro_addr),
  .rw_q       (rw_q),
  .ro_q       (ro_q),
  .rw_raw     (rw_raw),
  .ro_raw     (ro_raw),
  .rst_sync_n (rst_sync_n)
);

// File: tb/lutram_dp_tb.sv
`timescale 1ns/1ps
module lutram_dp_tb;
  import lutram_pkg::*;

  localparam logic [15:0] INIT_PAT = 16'hC3A5;

  logic       clk = 1'b0;
  logic       clk_n;
  logic       rst_n = 1'b1;
  logic       we_act = 1'b0;
  logic       we_n;
  logic       d = 1'b0;
  logic [3:0] a = '0;
  logic [3:0] pa = '0;

  logic q0_rw, q0_ro, q1_rw, q1_ro, q2_rw, q2_ro, q3_rw, q3_ro;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Reference state.
  logic       ref_mem [16];
  logic       s1 = 1'b0;
  logic       s2 = 1'b0;
  logic       er_rw = 1'b0;
  logic       er_ro = 1'b0;

  always #10 clk = ~clk;
  assign clk_n = ~clk;
  assign we_n  = ~we_act;

  // Rising clock, active-high enable, both reads combinational.
  lutram_dp #(.INIT(INIT_PAT), .CLK_INV(1'b0), .WE_INV(1'b0),
              .RW_MODE(RD_COMB), .RO_MODE(RD_COMB)) u_dut (
    .wr_clk(clk), .rst_n(rst_n), .wr_en(we_act), .wr_data(d),
    .rw_addr(a), .ro_addr(pa), .rw_q(q0_rw), .ro_q(q0_ro));

  // Falling clock (fed inverted), active-high enable, registered rw port.
  lutram_dp #(.INIT(INIT_PAT), .CLK_INV(1'b1), .WE_INV(1'b0),
              .RW_MODE(RD_REG), .RO_MODE(RD_COMB)) u_dut1 (
    .wr_clk(clk_n), .rst_n(rst_n), .wr_en(we_act), .wr_data(d),
    .rw_addr(a), .ro_addr(pa), .rw_q(q1_rw), .ro_q(q1_ro));

  // Rising clock, active-low enable, registered ro port.
  lutram_dp #(.INIT(INIT_PAT), .CLK_INV(1'b0), .WE_INV(1'b1),
              .RW_MODE(RD_COMB), .RO_MODE(RD_REG)) u_dut2 (
    .wr_clk(clk), .rst_n(rst_n), .wr_en(we_n), .wr_data(d),
    .rw_addr(a), .ro_addr(pa), .rw_q(q2_rw), .ro_q(q2_ro));

  // Falling clock, active-low enable, both ports registered.
  lutram_dp #(.INIT(INIT_PAT), .CLK_INV(1'b1), .WE_INV(1'b1),
              .RW_MODE(RD_REG), .RO_MODE(RD_REG)) u_dut3 (
    .wr_clk(clk_n), .rst_n(rst_n), .wr_en(we_n), .wr_data(d),
    .rw_addr(a), .ro_addr(pa), .rw_q(q3_rw), .ro_q(q3_ro));

  initial begin
    for (int i = 0; i < 16; i++) ref_mem[i] = INIT_PAT[i];
  end

  // Reference: registered reads take the pre-write value, reset releases
  // after two active edges (R8, R9); writes follow R2/R3.
  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 1'b0; s2 = 1'b0; er_rw = 1'b0; er_ro = 1'b0;
    end else begin
      if (s2) begin
        er_rw = ref_mem[a];
        er_ro = ref_mem[pa];
      end
      s2 = s1;
      s1 = 1'b1;
    end
    if (we_act) ref_mem[a] = d;
  end

  task automatic chk(input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " u_dut R4 rw"},           q0_rw, ref_mem[a]);
    chk({tag, " u_dut R4 ro"},           q0_ro, ref_mem[pa]);
    chk({tag, " u_dut1 R6 R8 rw"},       q1_rw, er_rw);
    chk({tag, " u_dut1 R6 ro"},          q1_ro, ref_mem[pa]);
    chk({tag, " u_dut2 R7 rw"},          q2_rw, ref_mem[a]);
    chk({tag, " u_dut2 R7 R8 ro"},       q2_ro, er_ro);
    chk({tag, " u_dut3 R6 R7 R8 rw"},    q3_rw, er_rw);
    chk({tag, " u_dut3 R6 R7 R8 ro"},    q3_ro, er_ro);
  endtask

  task automatic cyc(input logic w, input logic [3:0] ad, input logic dd,
                     input logic [3:0] ra, input string tag);
    @(negedge clk);
    we_act = w; a = ad; d = dd; pa = ra;
    #3 check_all({tag, " before edge"});
    @(posedge clk);
    #3 check_all({tag, " after edge"});
  endtask

  task automatic t_reset();
    #5 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #3;
    chk("R9 reset u_dut1 rw", q1_rw, 1'b0);
    chk("R9 reset u_dut2 ro", q2_ro, 1'b0);
    chk("R9 reset u_dut3 rw", q3_rw, 1'b0);
    chk("R9 reset u_dut3 ro", q3_ro, 1'b0);
    check_all("R9 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b0, 4'(i + 3), 1'b0, 4'(i + 3), "R9 release");
  endtask

  task automatic t_init_scan();
    for (int i = 0; i < 16; i++) begin
      cyc(1'b0, 4'(i), 1'b0, 4'(15 - i), "R1 init scan");
      chk("R1 init word rw", q0_rw, INIT_PAT[i]);
      chk("R1 init word ro", q0_ro, INIT_PAT[15 - i]);
    end
  endtask

  task automatic t_write_read();
    for (int i = 0; i < 16; i++)
      cyc(1'b1, 4'(i), ~INIT_PAT[i], 4'(i), "R2 R5 write same addr");
    for (int i = 0; i < 16; i++) begin
      cyc(1'b0, 4'(i), 1'b0, 4'((i + 5) % 16), "R2 readback");
      chk("R2 stored word", q0_rw, ~INIT_PAT[i]);
    end
  endtask

  task automatic t_we_off();
    for (int i = 0; i < 16; i++)
      cyc(1'b0, 4'(i), ~ref_mem[i], 4'(i), "R3 disabled write");
    for (int i = 0; i < 16; i++) begin
      cyc(1'b0, 4'(15 - i), 1'b1, 4'(i), "R3 readback");
      chk("R3 word unchanged", q0_rw, ~INIT_PAT[15 - i]);
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      logic [3:0] ra;
      logic [3:0] rb;
      ra = 4'($urandom_range(0, 15));
      rb = (i % 4 == 0) ? ra : 4'($urandom_range(0, 15));
      cyc(1'($urandom_range(0, 1)), ra, 1'($urandom_range(0, 1)), rb, "R4 R5 random");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_init_scan();
    t_write_read();
    t_we_off();
    t_random();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule